// File: doc/BRIEF.md
# Hardwired Control Signal Generator

This block is the combinational core of a small 32-bit hardwired control unit. It takes three inputs: the five opcode bits held in IR[31:27], the major machine state and the minor time step. From these it produces the individual control lines that steer the datapath. Those lines pick which register drives each of the two source buses, which registers load from the result bus, which ALU function runs, and the code placed on the shift control. They also raise the memory read and write strobes and clear the run flag.

Inside the block, the opcode is decoded into one-hot instruction lines. Separate trees then produce the lines for three windows: the last step of Fetch, the four steps of Defer, and steps T2 and T3 of Execute. Opcodes that share their upper bits share the lines those bits imply, so those lines are not decoded once per instruction. The sequencer that picks the next major state sits outside this block, and so does the datapath.

Top module: `ctl_siggen`

## Requirements
- R1: All outputs are 0 whenever the state is not Fetch T3, Defer, Execute T2 or Execute T3. This covers Fetch T0 to T2, Execute T0 and T1, and major code 3. Major codes are Fetch=0, Defer=1, Execute=2.
- R2: In Defer, T0 raises only mem_read. T1 and T3 raise nothing. T2 raises exactly these: b2_sel bit1 (MBR), alu_op bit1 (pass B2) and b3_load bit1 (MAR).
- R3: In Fetch T3, b2_sel bit0 (R) is 1 for all 32 opcodes. In the same state, b1_sel bit0 (IR) is 1 exactly when opcode bit 4 is 0.
- R4: In Fetch T3, opcodes 12 to 15 also raise b3_load bit1 (MAR) and alu_op bit2 (add), and nothing else.
- R5: In Fetch T3, opcode 0 raises run_clear. Opcodes 1, 2 and 3 load R (b3_load bit0) with, in that order, alu_op bit0 (pass B1), bit4 (and) and bit2 (add).
- R6: In Fetch T3, opcodes 20 to 25 load R with, in that order, not (bit7), add (bit2), sub (bit3), and (bit4), or (bit5) and xor (bit6). Opcodes 21 to 25 also raise b1_sel bit3 (R).
- R7: In Fetch T3, opcodes 16 to 19 load R with alu_op bit8 (shift). They set shift_ctl to 3'b100, 3'b101, 3'b000 and 3'b010 in that order. shift_ctl is 0 in every other case.
- R8: In Execute T2, each opcode below raises exactly its own lines:
  - 8 raises b2_sel bit2 (IOD), pass B2 and load R.
  - 9 raises b1_sel bit0 (IR), pass B1 and b3_load bit4 (IOA).
  - 12 raises MBR on B2, pass B2 and load R.
  - 14 raises b1_sel bit1 (SP), pass B1, load MAR and mem_write.
- R9: In Execute T3, each opcode below raises exactly its own lines:
  - 10 raises MBR on B2, pass B2 and b3_load bit2 (PC).
  - 14 raises SP on B1, b2_sel bit3 (constant 1), add and b3_load bit3 (SP).
  - 15 raises b1_sel bit2 (MAR), pass B1 and load PC.
- R10: Some opcodes have no action listed above for the current state. This includes the unused codes 4 to 7 and 26 to 31. Such opcodes raise no output beyond the Fetch T3 bus sources of R3.
- R11: b1_sel and b2_sel each have at most one bit set. alu_op has at most one bit set. mem_read and mem_write are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir_op | input | 5 | Opcode, IR[31:27] |
| major | input | 2 | Major state: 0 Fetch, 1 Defer, 2 Execute |
| minor | input | 2 | Minor time step T0..T3 |
| b1_sel | output | 4 | B1 source: bit0 IR, bit1 SP, bit2 MAR, bit3 R |
| b2_sel | output | 4 | B2 source: bit0 R, bit1 MBR, bit2 IOD, bit3 constant 1 |
| b3_load | output | 5 | Load from B3: bit0 R, bit1 MAR, bit2 PC, bit3 SP, bit4 IOA |
| alu_op | output | 9 | One-hot ALU function: pass B1, pass B2, add, sub, and, or, xor, not, shift |
| shift_ctl | output | 3 | Shift control code |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| run_clear | output | 1 | Clears the run flag |

## Verification
The bench builds the block with its default five-bit opcode field. That size makes exhaustive coverage cheap: all 32 opcodes cross all four major codes and all four minor steps. Every unused opcode and every idle state is therefore applied and compared, not sampled. Each vector is also checked for a single driver per bus, a single ALU function and exclusive read and write strobes.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W  = 5;
  localparam int N_OP  = 1 << OP_W;
  localparam int B1_W  = 4;
  localparam int B2_W  = 4;
  localparam int B3_W  = 5;
  localparam int ALU_W = 9;
  localparam int SH_W  = 3;
  localparam int ST_W  = 2;

  // B1 sources
  localparam int S1_IR = 0, S1_SP = 1, S1_MAR = 2, S1_R = 3;
  // B2 sources
  localparam int S2_R = 0, S2_MBR = 1, S2_IOD = 2, S2_ONE = 3;
  // B3 destinations
  localparam int D_R = 0, D_MAR = 1, D_PC = 2, D_SP = 3, D_IOA = 4;
  // ALU functions
  localparam int A_PASS1 = 0, A_PASS2 = 1, A_ADD = 2, A_SUB = 3, A_AND = 4,
                 A_OR = 5, A_XOR = 6, A_NOT = 7, A_SHIFT = 8;

  // opcode values
  localparam int OPC_HLT = 0,  OPC_LDI = 1,  OPC_ANDI = 2, OPC_ADDI = 3;
  localparam int OPC_GET = 8,  OPC_PUT = 9,  OPC_RET = 10;
  localparam int OPC_LDR = 12, OPC_JSR = 14, OPC_BR = 15;
  localparam int OPC_LLS = 16, OPC_LCS = 17, OPC_RLS = 18, OPC_RAS = 19;
  localparam int OPC_NOT = 20, OPC_ADD = 21, OPC_SUB = 22, OPC_AND = 23;
  localparam int OPC_OR  = 24, OPC_XOR = 25;

  typedef enum logic [ST_W-1:0] {
    MJ_FETCH = 2'd0,
    MJ_DEFER = 2'd1,
    MJ_EXEC  = 2'd2,
    MJ_NONE  = 2'd3
  } major_e;

  typedef struct packed {
    logic [B1_W-1:0]  b1;
    logic [B2_W-1:0]  b2;
    logic [B3_W-1:0]  b3;
    logic [ALU_W-1:0] alu;
    logic [SH_W-1:0]  sh;
    logic             rd;
    logic             wr;
    logic             run_clr;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '0;

  // OR-merge of two partial control bundles
  function automatic ctl_t ctl_merge(ctl_t a, ctl_t b);
    return ctl_t'(a | b);
  endfunction

  // shift code: {left, arithmetic, circular}
  function automatic logic [SH_W-1:0] shift_code(logic lls, logic lcs,
                                                 logic rls, logic ras);
    logic unused_rls;
    unused_rls = rls;
    return {lls | lcs, ras, lcs};
  endfunction

  // the three opcode bits that key the shared Fetch T3 groups
  function automatic logic mem_group(logic [2:0] hi);
    return (hi == 3'b011);
  endfunction
endpackage

// File: rtl/ctl_opdec.sv
module ctl_opdec #(
  parameter int OP_W = ctl_pkg::OP_W,
  localparam int N   = 1 << OP_W
) (
  input  logic [OP_W-1:0] op,
  output logic [N-1:0]    line
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign line[i] = (op == OP_W'(i));
  end
endmodule

// File: rtl/ctl_fetch_tree.sv
module ctl_fetch_tree
  import ctl_pkg::*;
(
  input  logic       en,
  input  logic [2:0] hi,      // IR31, IR30, IR29
  input  logic       i_hlt, i_ldi, i_andi, i_addi,
  input  logic       i_lls, i_lcs, i_rls, i_ras,
  input  logic       i_not, i_add, i_sub, i_and, i_or, i_xor,
  output ctl_t       c
);
  logic mem_grp, shift_grp, reg3_grp, load_r;

  assign mem_grp   = mem_group(hi);
  assign shift_grp = i_lls | i_lcs | i_rls | i_ras;
  assign reg3_grp  = i_add | i_sub | i_and | i_or | i_xor;
  assign load_r    = i_ldi | i_andi | i_addi | shift_grp | i_not | reg3_grp;

  always_comb begin
    c = CTL_IDLE;
    if (en) begin
      c.b2[S2_R]     = 1'b1;
      c.b1[S1_IR]    = ~hi[2];
      c.b1[S1_R]     = reg3_grp;
      c.b3[D_MAR]    = mem_grp;
      c.b3[D_R]      = load_r;
      c.alu[A_PASS1] = i_ldi;
      c.alu[A_ADD]   = mem_grp | i_addi | i_add;
      c.alu[A_AND]   = i_andi | i_and;
      c.alu[A_SUB]   = i_sub;
      c.alu[A_OR]    = i_or;
      c.alu[A_XOR]   = i_xor;
      c.alu[A_NOT]   = i_not;
      c.alu[A_SHIFT] = shift_grp;
      c.sh           = shift_grp ? shift_code(i_lls, i_lcs, i_rls, i_ras) : '0;
      c.run_clr      = i_hlt;
    end
  end

  always_comb begin
    if (en && !hi[2])
      assert_fetch_ir_b1_R3: assert (c.b1 == (B1_W'(1) << S1_IR))
        else $error("IR31=0 group must drive only IR on B1");
  end
endmodule

// File: rtl/ctl_defer_tree.sv
module ctl_defer_tree
  import ctl_pkg::*;
(
  input  logic            en,
  input  logic [ST_W-1:0] minor,
  output ctl_t            c
);
  logic step_read, step_xfer;

  assign step_read = en && (minor == 2'd0);
  assign step_xfer = en && (minor == 2'd2);

  always_comb begin
    c = CTL_IDLE;
    c.rd           = step_read;
    c.b2[S2_MBR]   = step_xfer;
    c.alu[A_PASS2] = step_xfer;
    c.b3[D_MAR]    = step_xfer;
  end

  always_comb begin
    if (en && minor[0])
      assert_defer_wait_R2: assert (c == CTL_IDLE)
        else $error("defer wait step asserted a line");
  end
endmodule

// File: rtl/ctl_exec_tree.sv
module ctl_exec_tree
  import ctl_pkg::*;
(
  input  logic en_t2,
  input  logic en_t3,
  input  logic i_get, i_put, i_ldr, i_jsr, i_ret, i_br,
  output ctl_t c
);
  logic get2, put2, ldr2, jsr2, ret3, jsr3, br3;

  assign get2 = en_t2 & i_get;
  assign put2 = en_t2 & i_put;
  assign ldr2 = en_t2 & i_ldr;
  assign jsr2 = en_t2 & i_jsr;
  assign ret3 = en_t3 & i_ret;
  assign jsr3 = en_t3 & i_jsr;
  assign br3  = en_t3 & i_br;

  always_comb begin
    c = CTL_IDLE;
    c.b1[S1_IR]    = put2;
    c.b1[S1_SP]    = jsr2 | jsr3;
    c.b1[S1_MAR]   = br3;
    c.b2[S2_IOD]   = get2;
    c.b2[S2_MBR]   = ldr2 | ret3;
    c.b2[S2_ONE]   = jsr3;
    c.alu[A_PASS1] = put2 | jsr2 | br3;
    c.alu[A_PASS2] = get2 | ldr2 | ret3;
    c.alu[A_ADD]   = jsr3;
    c.b3[D_R]      = get2 | ldr2;
    c.b3[D_IOA]    = put2;
    c.b3[D_MAR]    = jsr2;
    c.b3[D_PC]     = ret3 | br3;
    c.b3[D_SP]     = jsr3;
    c.wr           = jsr2;
  end

  always_comb begin
    assert_exec_steps_R8: assert (!(en_t2 && en_t3))
      else $error("execute T2 and T3 both enabled");
    if (c.wr)
      assert_exec_write_R8: assert (c.b3[D_MAR] && c.b1[S1_SP])
        else $error("write without SP-to-MAR transfer");
  end
endmodule

// File: rtl/ctl_siggen.sv
module ctl_siggen
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0]  ir_op,
  input  logic [ST_W-1:0]  major,
  input  logic [ST_W-1:0]  minor,
  output logic [B1_W-1:0]  b1_sel,
  output logic [B2_W-1:0]  b2_sel,
  output logic [B3_W-1:0]  b3_load,
  output logic [ALU_W-1:0] alu_op,
  output logic [SH_W-1:0]  shift_ctl,
  output logic             mem_read,
  output logic             mem_write,
  output logic             run_clear
);
  logic [N_OP-1:0] dec_line;
  logic st_fetch_t3, st_defer, st_exec_t2, st_exec_t3, st_covered;
  ctl_t c_fetch, c_defer, c_exec, c_all;

  assign st_fetch_t3 = (major_e'(major) == MJ_FETCH) && (minor == 2'd3);
  assign st_defer    = (major_e'(major) == MJ_DEFER);
  assign st_exec_t2  = (major_e'(major) == MJ_EXEC)  && (minor == 2'd2);
  assign st_exec_t3  = (major_e'(major) == MJ_EXEC)  && (minor == 2'd3);
  assign st_covered  = st_fetch_t3 | st_defer | st_exec_t2 | st_exec_t3;

  ctl_opdec #(.OP_W(OP_W)) u_dec (.op(ir_op), .line(dec_line));

  ctl_fetch_tree u_fetch (
    .en(st_fetch_t3), .hi(ir_op[OP_W-1 -: 3]),
    .i_hlt(dec_line[OPC_HLT]), .i_ldi(dec_line[OPC_LDI]),
    .i_andi(dec_line[OPC_ANDI]), .i_addi(dec_line[OPC_ADDI]),
    .i_lls(dec_line[OPC_LLS]), .i_lcs(dec_line[OPC_LCS]),
    .i_rls(dec_line[OPC_RLS]), .i_ras(dec_line[OPC_RAS]),
    .i_not(dec_line[OPC_NOT]), .i_add(dec_line[OPC_ADD]),
    .i_sub(dec_line[OPC_SUB]), .i_and(dec_line[OPC_AND]),
    .i_or(dec_line[OPC_OR]), .i_xor(dec_line[OPC_XOR]),
    .c(c_fetch)
  );

  ctl_defer_tree u_defer (.en(st_defer), .minor(minor), .c(c_defer));

  ctl_exec_tree u_exec (
    .en_t2(st_exec_t2), .en_t3(st_exec_t3),
    .i_get(dec_line[OPC_GET]), .i_put(dec_line[OPC_PUT]),
    .i_ldr(dec_line[OPC_LDR]), .i_jsr(dec_line[OPC_JSR]),
    .i_ret(dec_line[OPC_RET]), .i_br(dec_line[OPC_BR]),
    .c(c_exec)
  );

  assign c_all = ctl_merge(ctl_merge(c_fetch, c_defer), c_exec);

  assign b1_sel    = c_all.b1;
  assign b2_sel    = c_all.b2;
  assign b3_load   = c_all.b3;
  assign alu_op    = c_all.alu;
  assign shift_ctl = c_all.sh;
  assign mem_read  = c_all.rd;
  assign mem_write = c_all.wr;
  assign run_clear = c_all.run_clr;

  always_comb begin
    assert_dec_onehot_R10: assert ($onehot(dec_line))
      else $error("opcode decode not one-hot");
    assert_b1_single_R11: assert ($onehot0(b1_sel))
      else $error("two sources on B1");
    assert_b2_single_R11: assert ($onehot0(b2_sel))
      else $error("two sources on B2");
    assert_alu_single_R11: assert ($onehot0(alu_op))
      else $error("two ALU functions");
    assert_rw_excl_R11: assert (!(mem_read && mem_write))
      else $error("read and write together");
    if (!st_covered)
      assert_idle_quiet_R1: assert (c_all == CTL_IDLE)
        else $error("output active outside covered states");
    if (shift_ctl != '0)
      assert_shift_code_R7: assert (alu_op[A_SHIFT])
        else $error("shift code without shift function");
  end
endmodule

// File: tb/tb_ctl_siggen.sv
`timescale 1ns/1ps
module tb_ctl_siggen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] ir_op = '0;
  logic [1:0] major = '0, minor = '0;
  logic [3:0] b1_sel, b2_sel;
  logic [4:0] b3_load;
  logic [8:0] alu_op;
  logic [2:0] shift_ctl;
  logic mem_read, mem_write, run_clear;

  ctl_siggen dut (
    .ir_op(ir_op), .major(major), .minor(minor),
    .b1_sel(b1_sel), .b2_sel(b2_sel), .b3_load(b3_load), .alu_op(alu_op),
    .shift_ctl(shift_ctl), .mem_read(mem_read), .mem_write(mem_write),
    .run_clear(run_clear)
  );

  typedef struct packed {
    logic [3:0] b1; logic [3:0] b2; logic [4:0] b3; logic [8:0] alu;
    logic [2:0] sh; logic rd; logic wr; logic rc;
  } vec_t;

  typedef struct {
    int mj; int mn; int op; vec_t exp;
  } item_t;

  item_t sb_q[$];
  int total = 0, bad = 0;
  bit drv_done = 0;

  // reference model written from the requirements
  function automatic vec_t model(int mj, int mn, int op);
    vec_t v = '0;
    if (mj == 1) begin                                  // R2
      if (mn == 0) v.rd = 1;
      if (mn == 2) begin v.b2[1] = 1; v.alu[1] = 1; v.b3[1] = 1; end
    end else if (mj == 0 && mn == 3) begin
      v.b2[0] = 1;                                      // R3
      if (op < 16) v.b1[0] = 1;
      case (op)
        0: v.rc = 1;
        1: begin v.b3[0] = 1; v.alu[0] = 1; end
        2: begin v.b3[0] = 1; v.alu[4] = 1; end
        3: begin v.b3[0] = 1; v.alu[2] = 1; end
        12, 13, 14, 15: begin v.b3[1] = 1; v.alu[2] = 1; end
        16: begin v.b3[0] = 1; v.alu[8] = 1; v.sh = 3'b100; end
        17: begin v.b3[0] = 1; v.alu[8] = 1; v.sh = 3'b101; end
        18: begin v.b3[0] = 1; v.alu[8] = 1; v.sh = 3'b000; end
        19: begin v.b3[0] = 1; v.alu[8] = 1; v.sh = 3'b010; end
        20: begin v.b3[0] = 1; v.alu[7] = 1; end
        21: begin v.b3[0] = 1; v.b1[3] = 1; v.alu[2] = 1; end
        22: begin v.b3[0] = 1; v.b1[3] = 1; v.alu[3] = 1; end
        23: begin v.b3[0] = 1; v.b1[3] = 1; v.alu[4] = 1; end
        24: begin v.b3[0] = 1; v.b1[3] = 1; v.alu[5] = 1; end
        25: begin v.b3[0] = 1; v.b1[3] = 1; v.alu[6] = 1; end
        default: ;
      endcase
    end else if (mj == 2 && mn == 2) begin              // R8
      case (op)
        8:  begin v.b2[2] = 1; v.alu[1] = 1; v.b3[0] = 1; end
        9:  begin v.b1[0] = 1; v.alu[0] = 1; v.b3[4] = 1; end
        12: begin v.b2[1] = 1; v.alu[1] = 1; v.b3[0] = 1; end
        14: begin v.b1[1] = 1; v.alu[0] = 1; v.b3[1] = 1; v.wr = 1; end
        default: ;
      endcase
    end else if (mj == 2 && mn == 3) begin              // R9
      case (op)
        10: begin v.b2[1] = 1; v.alu[1] = 1; v.b3[2] = 1; end
        14: begin v.b1[1] = 1; v.b2[3] = 1; v.alu[2] = 1; v.b3[3] = 1; end
        15: begin v.b1[2] = 1; v.alu[0] = 1; v.b3[2] = 1; end
        default: ;
      endcase
    end
    return v;
  endfunction

  function automatic string tag_of(int mj, int mn, int op);
    if (mj == 1) return "R2";
    if (mj == 0 && mn == 3) begin
      if (op <= 3) return "R5";
      if (op >= 12 && op <= 15) return "R4";
      if (op >= 16 && op <= 19) return "R7";
      if (op >= 20 && op <= 25) return "R6";
      return "R10";
    end
    if (mj == 2 && mn == 2) return "R8";
    if (mj == 2 && mn == 3) return "R9";
    return "R1";
  endfunction

  function automatic vec_t observed();
    return {b1_sel, b2_sel, b3_load, alu_op, shift_ctl,
            mem_read, mem_write, run_clear};
  endfunction

  task automatic check(string req, string what, logic [27:0] got, logic [27:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic drive(int mj, int mn, int op);
    item_t it;
    @(posedge clk);
    major = 2'(mj); minor = 2'(mn); ir_op = 5'(op);
    it.mj = mj; it.mn = mn; it.op = op; it.exp = model(mj, mn, op);
    sb_q.push_back(it);
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      vec_t got;
      string tg;
      it  = sb_q.pop_front();
      got = observed();
      tg  = tag_of(it.mj, it.mn, it.op);
      check(tg, $sformatf("mj=%0d mn=%0d op=%0d", it.mj, it.mn, it.op),
            28'(got), 28'(it.exp));
      if (it.mj == 0 && it.mn == 3)
        check("R3", $sformatf("shared sources op=%0d", it.op),
              28'({got.b1[0], got.b2[0]}),
              28'({(it.op < 16) ? 1'b1 : 1'b0, 1'b1}));
      check("R11", $sformatf("exclusivity op=%0d", it.op),
            28'({$countones(got.b1) <= 1, $countones(got.b2) <= 1,
                 $countones(got.alu) <= 1, !(got.rd && got.wr)}),
            28'(4'b1111));
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset state fetch T0", 28'(observed()), 28'(0));
    rst_n = 1'b1;
    for (int mj = 0; mj < 4; mj++)
      for (int mn = 0; mn < 4; mn++)
        for (int op = 0; op < 32; op++)
          drive(mj, mn, op);
    drv_done = 1;
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=done (drv_done=%0d)", drv_done);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule